// File: doc/BRIEF.md
# Memory Protection Region Checker

This block judges every memory access of a processor core against a small set of software-programmed protection regions. Each access arrives as an address together with three flags: write, instruction fetch and privileged. In the same cycle the block answers whether the access may proceed or must raise a memory-management fault. When the answer comes from a region, it also reports which region won and passes on that region's six memory-type attribute bits without change. Cache policy, bus routing and exception entry are handled elsewhere.

Software configures the checker through a four-word register port. One word holds the global enable and the privileged background-map enable. One selects the region to program. One holds the region base address, and that same write can also select the region. The last holds the region's enable, size code, subregion-disable mask, memory-type bits, access permission and execute-never flag. Regions may overlap. The highest-numbered matching region wins. A disabled subregion makes its region transparent, so lower regions or the background map then decide the access.

Top module: `memRegionGuard`

## Requirements
- R1: Up to NUM_REGIONS (default 8) regions are held. When several regions match an address, the highest-numbered one supplies the permission, the attributes and `accRegion`.
- R2: While the global enable (control word bit 0) is 0, every access is allowed, `accHit` is 0 and `accAttr` is 0.
- R3: A size code N in attribute bits [5:1] gives a region of 2^(N+1) bytes. An enabled region (attribute bit 0) matches when address bits [31:N+1] equal its base bits [31:N+1]. Size codes 0 to 3 never match.
- R4: Attribute bits [15:8] disable eighths of a region. Subregion k covers the addresses whose bits [N:N-2] equal k. An access to a disabled eighth ignores that region and is judged by lower matching regions or by the background rule.
- R5: For size codes 6 and below (128 bytes or less), the subregion-disable bits have no effect.
- R6: When no region matches, a privileged access is allowed only if the background enable (control word bit 1) is 1. An unprivileged access always faults.
- R7: The permission code in attribute bits [26:24] decodes as follows. 0 and 4: no access. 1: privileged read/write only. 2: privileged read/write plus unprivileged read. 3: full access. 5: privileged read only. 6 and 7: read only for both levels.
- R8: An instruction fetch counts as a read, whatever the write flag says. A fetch that hits a region whose execute-never flag (attribute bit 28) is set always faults.
- R9: On a hit, `accAttr` equals attribute bits [21:16] of the winning region. Without a hit, `accAttr` is 0. `accFault` is always the inverse of `accAllow`.
- R10: The register words are 0 = control, 1 = region select, 2 = base, 3 = attributes. Writes take effect at the next clock edge. Reading word 2 returns the selected region's base in bits [31:5], 0 in bit 4, and the select number in bits [3:0]. Reading word 3 returns the selected region's fields at the positions above.
- R11: A base write with bit 4 set moves the selection to bits [3:0] and writes that region's base. If that number is NUM_REGIONS or higher, the whole write is ignored and the selection is unchanged.
- R12: After reset, all four register words read 0 and every region is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register word index |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for regAddr |
| reqAddr | input | 32 | Access address |
| reqWrite | input | 1 | Access is a write |
| reqFetch | input | 1 | Access is an instruction fetch |
| reqPriv | input | 1 | Access is privileged |
| accAllow | output | 1 | Access permitted |
| accFault | output | 1 | Memory-management fault |
| accHit | output | 1 | A region decided the access |
| accRegion | output | $clog2(NUM_REGIONS) | Winning region number (0 without a hit) |
| accAttr | output | 6 | Memory-type bits of the winning region |

## Verification
The bench programs a dense overlapping layout and sweeps addresses at sub-32-byte granularity, driving every combination of the write, fetch and privileged flags. A priority resolver that picked the lowest region would report the wrong `accRegion` and the wrong attributes inside nested windows. A subregion mask that blocked the access instead of letting it fall through would fault inside region 0's span. A mask applied to a 128-byte region would make that region vanish. A reserved size code that matched would fault the whole bottom of memory. Further sweeps cover the 4 GB region with its top eighth masked, including the boundary where a 32-bit shift overflows. They also cover the background rule with the background enable on and off, a base write whose region number lies beyond the implemented regions, and readback of every register field.

// File: rtl/mrg_pkg.sv
package mrg_pkg;

  localparam int ADDR_W   = 32;
  localparam int BASE_LSB = 5;

  // register word indices
  localparam logic [1:0] WORD_CTRL = 2'd0;
  localparam logic [1:0] WORD_SEL  = 2'd1;
  localparam logic [1:0] WORD_BASE = 2'd2;
  localparam logic [1:0] WORD_ATTR = 2'd3;

  // attribute word field positions
  localparam int ATTR_EN_BIT = 0;
  localparam int SIZE_LSB    = 1;
  localparam int SRD_LSB     = 8;
  localparam int TYPE_LSB    = 16;
  localparam int AP_LSB      = 24;
  localparam int XN_BIT      = 28;
  localparam int VALID_BIT   = 4;

  typedef struct packed {
    logic                       en;
    logic [4:0]                 sizeCode;
    logic [7:0]                 srd;
    logic [5:0]                 memType;
    logic [2:0]                 ap;
    logic                       xn;
    logic [ADDR_W-1:BASE_LSB]   base;
  } regionCfg_t;

  typedef struct packed {
    logic        wrBase;
    logic        wrAttr;
    logic [3:0]  tgt;
    logic [31:0] data;
  } regStrobe_t;

  function automatic logic apPermits(input logic [2:0] ap, input logic priv,
                                     input logic isWrite);
    logic ok;
    case (ap)
      3'd1:    ok = priv;
      3'd2:    ok = priv || !isWrite;
      3'd3:    ok = 1'b1;
      3'd5:    ok = priv && !isWrite;
      3'd6,
      3'd7:    ok = !isWrite;
      default: ok = 1'b0;
    endcase
    return ok;
  endfunction

  function automatic logic [31:0] packAttr(input regionCfg_t c);
    logic [31:0] w;
    w = '0;
    w[ATTR_EN_BIT]       = c.en;
    w[SIZE_LSB +: 5]     = c.sizeCode;
    w[SRD_LSB +: 8]      = c.srd;
    w[TYPE_LSB +: 6]     = c.memType;
    w[AP_LSB +: 3]       = c.ap;
    w[XN_BIT]            = c.xn;
    return w;
  endfunction

endpackage

// File: rtl/mrg_ctrl.sv
module mrg_ctrl
  import mrg_pkg::*;
#(
  parameter int NUM_REGIONS = 8,
  parameter int REG_IDX_W   = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWrEn,
  input  logic [1:0]           regAddr,
  input  logic [31:0]          regWrData,
  output regStrobe_t           strobe,
  output logic                 gEnable,
  output logic                 privDef,
  output logic [REG_IDX_W-1:0] selIdx
);

  logic       baseWrite;
  logic       validReq;
  logic [3:0] regionFld;
  logic       regionOk;
  logic       selOk;

  always_comb begin
    validReq  = regWrData[VALID_BIT];
    regionFld = regWrData[3:0];
    regionOk  = ({28'd0, regionFld} < 32'(NUM_REGIONS));
    selOk     = ({28'd0, regWrData[3:0]} < 32'(NUM_REGIONS));
    baseWrite = regWrEn && (regAddr == WORD_BASE);

    strobe.wrBase = baseWrite && (!validReq || regionOk);
    strobe.tgt    = (baseWrite && validReq) ? regionFld : 4'(selIdx);
    strobe.wrAttr = regWrEn && (regAddr == WORD_ATTR);
    strobe.data   = regWrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gEnable <= 1'b0;
      privDef <= 1'b0;
      selIdx  <= '0;
    end else if (regWrEn) begin
      if (regAddr == WORD_CTRL) begin
        gEnable <= regWrData[0];
        privDef <= regWrData[1];
      end
      if (regAddr == WORD_SEL && selOk)
        selIdx <= regWrData[REG_IDX_W-1:0];
      if (baseWrite && validReq && regionOk)
        selIdx <= regionFld[REG_IDX_W-1:0];
    end
  end

endmodule

// File: rtl/mrg_match.sv
module mrg_match
  import mrg_pkg::*;
(
  input  regionCfg_t        cfg,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);

  logic [ADDR_W:0]   span;
  logic [ADDR_W-1:0] highMask;
  logic [2:0]        subIdx;
  logic              inRange;
  logic              subOff;
  logic              sizeLegal;

  always_comb begin
    span      = (ADDR_W+1)'(1) << ({1'b0, cfg.sizeCode} + 6'd1);
    highMask  = ~(span[ADDR_W-1:0] - 1'b1);
    inRange   = ((addr ^ {cfg.base, {BASE_LSB{1'b0}}}) & highMask) == '0;
    subIdx    = 3'(addr >> (cfg.sizeCode - 5'd2));
    subOff    = (cfg.sizeCode >= 5'd7) && cfg.srd[subIdx];
    sizeLegal = cfg.sizeCode >= 5'd4;
    hit       = cfg.en && sizeLegal && inRange && !subOff;
  end

endmodule

// File: rtl/mrg_datapath.sv
module mrg_datapath
  import mrg_pkg::*;
#(
  parameter int NUM_REGIONS = 8,
  parameter int REG_IDX_W   = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  regStrobe_t           strobe,
  input  logic                 gEnable,
  input  logic                 privDef,
  input  logic [REG_IDX_W-1:0] selIdx,
  input  logic [1:0]           regAddr,
  output logic [31:0]          regRdData,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic                 reqWrite,
  input  logic                 reqFetch,
  input  logic                 reqPriv,
  output logic                 accAllow,
  output logic                 accFault,
  output logic                 accHit,
  output logic [REG_IDX_W-1:0] accRegion,
  output logic [5:0]           accAttr,
  output logic                 winXn
);

  regionCfg_t              regs [NUM_REGIONS];
  logic [NUM_REGIONS-1:0]  hitVec;
  logic                    anyHit;
  logic [REG_IDX_W-1:0]    win;
  regionCfg_t              winCfg;
  regionCfg_t              selCfg;
  logic                    isWrite;
  logic                    permOk;

  for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_region
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        regs[r] <= '0;
      end else begin
        if (strobe.wrBase && strobe.tgt == 4'(r))
          regs[r].base <= strobe.data[ADDR_W-1:BASE_LSB];
        if (strobe.wrAttr && strobe.tgt == 4'(r)) begin
          regs[r].en       <= strobe.data[ATTR_EN_BIT];
          regs[r].sizeCode <= strobe.data[SIZE_LSB +: 5];
          regs[r].srd      <= strobe.data[SRD_LSB +: 8];
          regs[r].memType  <= strobe.data[TYPE_LSB +: 6];
          regs[r].ap       <= strobe.data[AP_LSB +: 3];
          regs[r].xn       <= strobe.data[XN_BIT];
        end
      end
    end

    mrg_match u_match (
      .cfg  (regs[r]),
      .addr (reqAddr),
      .hit  (hitVec[r])
    );
  end

  // priority: later (higher) index overrides
  always_comb begin
    anyHit = 1'b0;
    win    = '0;
    for (int r = 0; r < NUM_REGIONS; r++) begin
      if (hitVec[r]) begin
        anyHit = 1'b1;
        win    = REG_IDX_W'(r);
      end
    end
    winCfg  = regs[win];
    isWrite = reqWrite && !reqFetch;
    permOk  = apPermits(winCfg.ap, reqPriv, isWrite) && !(reqFetch && winCfg.xn);
    winXn   = winCfg.xn;

    if (!gEnable) begin
      accAllow  = 1'b1;
      accHit    = 1'b0;
      accAttr   = '0;
      accRegion = '0;
    end else if (anyHit) begin
      accAllow  = permOk;
      accHit    = 1'b1;
      accAttr   = winCfg.memType;
      accRegion = win;
    end else begin
      accAllow  = reqPriv && privDef;
      accHit    = 1'b0;
      accAttr   = '0;
      accRegion = '0;
    end
    accFault = !accAllow;
  end

  always_comb begin
    selCfg = regs[selIdx];
    case (regAddr)
      WORD_CTRL: regRdData = {30'd0, privDef, gEnable};
      WORD_SEL:  regRdData = 32'(selIdx);
      WORD_BASE: regRdData = {selCfg.base, 1'b0, 4'(selIdx)};
      default:   regRdData = packAttr(selCfg);
    endcase
  end

endmodule

// File: rtl/memRegionGuard.sv
module memRegionGuard
  import mrg_pkg::*;
#(
  parameter int NUM_REGIONS = 8,
  localparam int REG_IDX_W  = $clog2(NUM_REGIONS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWrEn,
  input  logic [1:0]           regAddr,
  input  logic [31:0]          regWrData,
  output logic [31:0]          regRdData,
  input  logic [31:0]          reqAddr,
  input  logic                 reqWrite,
  input  logic                 reqFetch,
  input  logic                 reqPriv,
  output logic                 accAllow,
  output logic                 accFault,
  output logic                 accHit,
  output logic [REG_IDX_W-1:0] accRegion,
  output logic [5:0]           accAttr
);

  regStrobe_t           strobe;
  logic                 gEnable;
  logic                 privDef;
  logic [REG_IDX_W-1:0] selIdx;
  logic                 winXn;

  mrg_ctrl #(.NUM_REGIONS(NUM_REGIONS), .REG_IDX_W(REG_IDX_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .strobe    (strobe),
    .gEnable   (gEnable),
    .privDef   (privDef),
    .selIdx    (selIdx)
  );

  mrg_datapath #(.NUM_REGIONS(NUM_REGIONS), .REG_IDX_W(REG_IDX_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .gEnable   (gEnable),
    .privDef   (privDef),
    .selIdx    (selIdx),
    .regAddr   (regAddr),
    .regRdData (regRdData),
    .reqAddr   (reqAddr),
    .reqWrite  (reqWrite),
    .reqFetch  (reqFetch),
    .reqPriv   (reqPriv),
    .accAllow  (accAllow),
    .accFault  (accFault),
    .accHit    (accHit),
    .accRegion (accRegion),
    .accAttr   (accAttr),
    .winXn     (winXn)
  );

endmodule

// File: rtl/mrg_checker.sv
module mrg_checker (
  input logic        clk,
  input logic        rstN,
  input logic        regWrEn,
  input logic [1:0]  regAddr,
  input logic [31:0] regWrData,
  input logic        gEnable,
  input logic        privDef,
  input logic        reqPriv,
  input logic        reqFetch,
  input logic        accAllow,
  input logic        accHit,
  input logic [5:0]  accAttr,
  input logic        winXn
);

  // R2
  disabled_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    !gEnable |-> (accAllow && !accHit && accAttr == 6'd0));

  // R6
  unpriv_miss_chk: assert property (@(posedge clk) disable iff (!rstN)
    (gEnable && !accHit && !reqPriv) |-> !accAllow);

  // R6
  priv_background_chk: assert property (@(posedge clk) disable iff (!rstN)
    (gEnable && !accHit && reqPriv) |-> (accAllow == privDef));

  // R8
  xn_fetch_chk: assert property (@(posedge clk) disable iff (!rstN)
    (gEnable && accHit && reqFetch && winXn) |-> !accAllow);

  // R9
  attr_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !accHit |-> (accAttr == 6'd0));

  // R10
  ctrl_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == 2'd0) |=>
      (gEnable == $past(regWrData[0]) && privDef == $past(regWrData[1])));

endmodule

bind memRegionGuard mrg_checker u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .regWrEn   (regWrEn),
  .regAddr   (regAddr),
  .regWrData (regWrData),
  .gEnable   (gEnable),
  .privDef   (privDef),
  .reqPriv   (reqPriv),
  .reqFetch  (reqFetch),
  .accAllow  (accAllow),
  .accHit    (accHit),
  .accAttr   (accAttr),
  .winXn     (winXn)
);

// File: tb/memRegionGuard_bench.sv
module memRegionGuard_bench;

  localparam int NR = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [31:0] reqAddr = '0;
  logic        reqWrite = 1'b0;
  logic        reqFetch = 1'b0;
  logic        reqPriv = 1'b0;
  logic        accAllow, accFault, accHit;
  logic [2:0]  accRegion;
  logic [5:0]  accAttr;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // bench-side model of the programmed state
  bit          mEn, mPd;
  int unsigned mBase [NR];
  int          mSize [NR];
  bit [7:0]    mSrd  [NR];
  int          mAp   [NR];
  bit          mXn   [NR];
  bit [5:0]    mType [NR];
  bit          mOn   [NR];

  always #10 clk = ~clk;  // 50 MHz

  memRegionGuard #(.NUM_REGIONS(NR)) u_memRegionGuard (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .reqAddr(reqAddr),
    .reqWrite(reqWrite), .reqFetch(reqFetch), .reqPriv(reqPriv),
    .accAllow(accAllow), .accFault(accFault), .accHit(accHit),
    .accRegion(accRegion), .accAttr(accAttr)
  );

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdCheck(input logic [1:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    regAddr = a;
    #2;
    checks++;
    if (regRdData !== exp) begin
      failures++;
      $display("FAIL %s word %0d: got %h expected %h", tag, a, regRdData, exp);
    end
  endtask

  task automatic setCtrl(input bit en, input bit pd);
    wr(2'd0, {30'd0, pd, en});
    mEn = en; mPd = pd;
  endtask

  function automatic logic [31:0] attrWord(input int r);
    logic [31:0] w;
    w = '0;
    w[0] = mOn[r]; w[5:1] = 5'(mSize[r]); w[15:8] = mSrd[r];
    w[21:16] = mType[r]; w[26:24] = 3'(mAp[r]); w[28] = mXn[r];
    return w;
  endfunction

  task automatic setRegion(input int r, input int unsigned base, input int size,
                           input bit [7:0] srd, input int ap, input bit xn,
                           input bit [5:0] typ, input bit on);
    mBase[r] = base & 32'hFFFF_FFE0; mSize[r] = size; mSrd[r] = srd;
    mAp[r] = ap; mXn[r] = xn; mType[r] = typ; mOn[r] = on;
    wr(2'd2, (base & 32'hFFFF_FFE0) | 32'h10 | 32'(r));
    wr(2'd3, attrWord(r));
  endtask

  function automatic void model(input logic [31:0] a, input bit w, input bit f,
                                input bit p, output bit allow, output bit hit,
                                output int eReg, output bit [5:0] attr);
    longint unsigned sz, part;
    int ap;
    bit rd, wrOk;
    hit = 0; eReg = 0; attr = 0; allow = 1;
    if (!mEn) return;
    for (int r = NR - 1; r >= 0; r--) begin
      if (!hit && mOn[r] && mSize[r] >= 4) begin
        sz = 64'd1 << (mSize[r] + 1);
        if ((64'(a) / sz) == (64'(mBase[r]) / sz)) begin
          part = (64'(a) % sz) / (sz / 8);
          if (!(sz > 128 && mSrd[r][part])) begin
            hit = 1; eReg = r;
          end
        end
      end
    end
    if (hit) begin
      ap = mAp[eReg];
      attr = mType[eReg];
      if (p) begin
        rd = (ap != 0 && ap != 4);
        wrOk = (ap >= 1 && ap <= 3);
      end else begin
        rd = (ap == 2 || ap == 3 || ap == 6 || ap == 7);
        wrOk = (ap == 3);
      end
      if (f) allow = rd && !mXn[eReg];
      else if (w) allow = wrOk;
      else allow = rd;
    end else begin
      allow = p && mPd;
    end
  endfunction

  task automatic checkAccess(input logic [31:0] a, input bit w, input bit f,
                             input bit p, input string tag);
    bit eAllow, eHit;
    int eReg;
    bit [5:0] eAttr;
    @(negedge clk);
    reqAddr = a; reqWrite = w; reqFetch = f; reqPriv = p;
    #2;
    model(a, w, f, p, eAllow, eHit, eReg, eAttr);
    checks++;
    if (accAllow !== eAllow || accFault !== !eAllow || accHit !== eHit ||
        accAttr !== eAttr || (eHit && int'(accRegion) != eReg)) begin
      failures++;
      $display("FAIL %s addr=%h w=%0d f=%0d p=%0d: got allow=%0d fault=%0d hit=%0d reg=%0d attr=%h expected allow=%0d hit=%0d reg=%0d attr=%h",
               tag, a, w, f, p, accAllow, accFault, accHit, accRegion, accAttr,
               eAllow, eHit, eReg, eAttr);
    end
  endtask

  task automatic sweep(input longint unsigned lo, input longint unsigned hi,
                       input longint unsigned step, input string tag);
    for (longint unsigned a = lo; a < hi; a += step) begin
      for (int m = 0; m < 8; m++) begin
        checkAccess(32'(a + ((a / step) % 32)), m[0], m[1], m[2], tag);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int r = 0; r < NR; r++) begin
      mBase[r] = 0; mSize[r] = 0; mSrd[r] = 0; mAp[r] = 0;
      mXn[r] = 0; mType[r] = 0; mOn[r] = 0;
    end
    mEn = 0; mPd = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R12: reset state of every word
    for (int a = 0; a < 4; a++) rdCheck(2'(a), 32'd0, "R12 reset readback");

    // R11: VALID base write with out-of-range region is ignored
    wr(2'd1, 32'd2);
    mBase[2] = 32'h0000_4000;
    wr(2'd2, 32'h0000_4000);
    rdCheck(2'd1, 32'd2, "R10 select readback");
    wr(2'd2, 32'hABC0_0000 | 32'h10 | 32'd9);
    rdCheck(2'd1, 32'd2, "R11 out-of-range select kept");
    rdCheck(2'd2, 32'h0000_4002, "R11 out-of-range base not written");
    wr(2'd2, 32'h1234_5660 | 32'h10 | 32'd5);
    mBase[5] = 32'h1234_5660;
    rdCheck(2'd1, 32'd5, "R11 VALID moves select");
    rdCheck(2'd2, 32'h1234_5665, "R11 VALID writes base");

    // R6: enabled, no regions
    setCtrl(1, 0);
    rdCheck(2'd0, 32'd1, "R10 control readback");
    sweep(0, 32'h400, 32, "R6 no region, background off");
    setCtrl(1, 1);
    rdCheck(2'd0, 32'd3, "R10 control readback both bits");
    sweep(0, 32'h400, 32, "R6 no region, background on");

    // layered layout, programmed while disabled
    setCtrl(0, 0);
    setRegion(0, 32'h0000_0000, 12, 8'h00, 3, 0, 6'h11, 1);
    setRegion(2, 32'h0000_0800, 10, 8'h0C, 6, 0, 6'h22, 1);
    setRegion(5, 32'h0000_1000,  9, 8'h00, 1, 1, 6'h05, 1);
    setRegion(7, 32'h0000_1400,  7, 8'hA5, 2, 0, 6'h3F, 1);
    setRegion(4, 32'h0000_1900,  6, 8'hFF, 5, 0, 6'h0A, 1);
    setRegion(6, 32'h0000_0000,  2, 8'h00, 0, 0, 6'h01, 1);
    setRegion(3, 32'h0000_1F00,  4, 8'h00, 0, 0, 6'h30, 1);
    wr(2'd1, 32'd7);
    rdCheck(2'd3, attrWord(7), "R10 attribute readback");
    rdCheck(2'd2, 32'h0000_1407, "R10 base readback");
    sweep(0, 32'h3000, 64, "R2 global enable clear");

    setCtrl(1, 0);
    sweep(0, 32'h3000, 32, "R1 R3 R4 R5 R7 R8 R9 layout, background off");
    setCtrl(1, 1);
    sweep(0, 32'h3000, 32, "R1 R4 R6 R7 R8 R9 layout, background on");

    // 4 GB region with its top eighth disabled
    setRegion(1, 32'h0000_0000, 31, 8'h80, 3, 0, 6'h2A, 1);
    sweep(0, 64'h1_0000_0000, 64'h0100_0000, "R3 R4 4GB region");
    setCtrl(1, 0);
    sweep(64'hC000_0000, 64'h1_0000_0000, 64'h0080_0000, "R4 R6 4GB top eighth");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule